// File: doc/BRIEF.md
# MDIO Frame Master

This block runs the two-wire PHY management bus (MDC clock, bidirectional MDIO data) from one 32-bit frame word. A host write of the word starts a frame. The block first sends a run of '1' bits as a preamble. It then shifts the word onto MDIO, most significant bit first. The word reads as start bits [31:30], operation [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. On a read-type frame the block stops driving the line for the turnaround and data bits. It samples the 16 data bits from the PHY into the data field.

The frame word is the shift register itself. Each bit sent is rotated back into the low end, so the word comes back whole when the frame ends. For read-type frames the sampled PHY bits take the place of the data field. The start, operation and turnaround bits go out exactly as written, even when they do not form a valid management frame. A completion flag and interrupt tell the host when the word may be used again. A status word shows the flag and a busy bit.

Top module: `mdio_frame_master`

## Requirements
- R1: Out of reset and between frames, mdc is low, mdio_oe is low, mdio_o is high, irq is low and the status word (host_addr=1) reads 0.
- R2: A host write with host_addr=0 while idle starts a frame. MDC toggles every CLK_DIV clocks. A frame is PRE_LEN+32 MDC periods long, so busy stays set for exactly 2*CLK_DIV*(PRE_LEN+32) clocks after the write edge.
- R3: The first PRE_LEN MDC periods of a frame carry mdio_o=1 with mdio_oe=1.
- R4: Next come the word's 32 bits, bit 31 first, one per MDC period. Each bit changes after a falling MDC edge and is stable at the rising edge. The start, operation and turnaround bits go out unchanged whatever their values.
- R5: If bit 29 of the word is 0 (operation 00 or 01), the frame is write-type and mdio_oe stays high for every bit period.
- R6: If bit 29 is 1 (operation 10 or 11), the frame is read-type. mdio_oe is low during the two turnaround and the sixteen data bit periods, and high for the first 14 frame bits.
- R7: On a read-type frame, mdio_i is sampled at each rising MDC edge of the data bits, MSB first. After completion the frame word reads {original[31:16], sampled data}.
- R8: After a write-type frame completes, the frame word reads back exactly as written.
- R9: At frame completion, status bit 0 and irq go high and stay high. Only a status write (host_addr=1) with bit 0 set clears them; a status write with bit 0 clear has no effect.
- R10: Status bit 1 reads 1 while a frame is active and 0 otherwise.
- R11: A frame-word write during an active frame replaces the shift contents at once. It does not restart or lengthen the frame. The read/write type stays the one latched at the frame's start. A write during the preamble therefore sends the new word in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 selects the frame word, 1 the status word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the word chosen by host_addr |
| irq | output | 1 | Completion interrupt, level, write-1-to-clear |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
Three corner cases get directed tests. The first is frames whose start, operation or turnaround fields are invalid. A design that cleaned these fields up, or decoded the frame type from the full operation code instead of bit 29, would send the wrong bits or release the bus at the wrong time. The second is read-back: a shifter that did not rotate, or that placed captured bits in the wrong order, would leave a corrupted or bit-reversed word. The third is a frame-word write during the preamble: a design that restarted the frame, ignored the write or re-decoded the type from the new word would show a wrong frame length, the old bits or a released bus. The write-1-to-clear rule is also tested with a status write of 0, which a careless clear would act on.

// File: rtl/mdio_fm_pkg.sv
`timescale 1ns/1ps
package mdio_fm_pkg;
   localparam int FRAME_W    = 32;  // bits per frame word
   localparam int DATA_W     = 16;  // data field width
   localparam int OP_RD_POS  = 29;  // word bit that selects a read-type frame
   localparam int TA_FIRST   = 14;  // frame bit slot of the first turnaround bit
   localparam int DATA_FIRST = 16;  // frame bit slot of the first data bit
   localparam int STAT_IRQ   = 0;   // status word: completion flag
   localparam int STAT_BUSY  = 1;   // status word: frame active

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PRE   = 2'd1,
      PH_FRAME = 2'd2
   } phase_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);
   logic toggle;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("mdio_mdc_gen: CLK_DIV must be at least 1");
   end

   generate
      if (CLK_DIV == 1) begin : g_div1
         assign toggle = run;
      end else begin : g_divn
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign toggle = run && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mdc <= 1'b0;
      else if (!run)   mdc <= 1'b0;
      else if (toggle) mdc <= ~mdc;
   end

   assign rise_evt = toggle && !mdc;
   assign fall_evt = toggle && mdc;

   AST_MDC_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc); // R1
   AST_MDC_EDGE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !rise_evt && !fall_evt) |=> $stable(mdc)); // R2
endmodule

// File: rtl/mdio_sequencer.sv
`timescale 1ns/1ps
module mdio_sequencer
   import mdio_fm_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_rd,
   input  logic fall_evt,
   output logic busy,
   output logic in_pre,
   output logic shift_en,
   output logic use_cap,
   output logic drive_en,
   output logic done
);
   localparam int SLOT_MAX = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
   localparam int SW = $clog2(SLOT_MAX);
   localparam logic [SW-1:0] PRE_LAST = SW'((PRE_LEN > 0) ? PRE_LEN - 1 : 0);
   localparam logic [SW-1:0] FRM_LAST = SW'(FRAME_W - 1);
   localparam logic [SW-1:0] TA_IDX   = SW'(TA_FIRST);
   localparam logic [SW-1:0] DAT_IDX  = SW'(DATA_FIRST);
   localparam phase_t FIRST_PH = (PRE_LEN == 0) ? PH_FRAME : PH_PRE;

   if (PRE_LEN < 0) begin : g_bad_pre
      $error("mdio_sequencer: PRE_LEN must not be negative");
   end

   phase_t        phase;
   logic [SW-1:0] slot;
   logic          rd_type;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         slot    <= '0;
         rd_type <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase   <= FIRST_PH;
               slot    <= '0;
               rd_type <= start_rd;
            end
            PH_PRE: if (fall_evt) begin
               if (slot == PRE_LAST) begin
                  phase <= PH_FRAME;
                  slot  <= '0;
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            PH_FRAME: if (fall_evt) begin
               if (slot == FRM_LAST) begin
                  phase <= PH_IDLE;
                  slot  <= '0;
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign in_pre   = (phase == PH_PRE);
   assign shift_en = (phase == PH_FRAME) && fall_evt;
   assign use_cap  = rd_type && (phase == PH_FRAME) && (slot >= DAT_IDX);
   assign drive_en = (phase == PH_PRE) ||
                     ((phase == PH_FRAME) && !(rd_type && (slot >= TA_IDX)));
   assign done     = (phase == PH_FRAME) && fall_evt && (slot == FRM_LAST);

   AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R11
   AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rd_type)); // R11
endmodule

// File: rtl/mdio_frame_reg.sv
`timescale 1ns/1ps
module mdio_frame_reg
   import mdio_fm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift_en,
   input  logic               use_cap,
   input  logic               rise_evt,
   input  logic               mdio_i,
   output logic [FRAME_W-1:0] word
);
   logic cap_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_bit <= 1'b1;
      else if (rise_evt) cap_bit <= mdio_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (load)     word <= load_val;
      else if (shift_en) word <= {word[FRAME_W-2:0], (use_cap ? cap_bit : word[FRAME_W-1])};
   end

   AST_HOLD_BETWEEN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift_en) |=> $stable(word)); // R4
   AST_ROTATE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load && !use_cap) |=> (word[0] == $past(word[FRAME_W-1]))); // R8
endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
   import mdio_fm_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        irq,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic               busy, in_pre, shift_en, use_cap, drive_en, done;
   logic               rise_evt, fall_evt;
   logic               frame_load, start, stat_wr, irq_flag;
   logic [FRAME_W-1:0] word;

   assign frame_load = host_wr && !host_addr;
   assign start      = frame_load && !busy;
   assign stat_wr    = host_wr && host_addr;

   mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
   );

   mdio_sequencer #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_rd(host_wdata[OP_RD_POS]),
      .fall_evt(fall_evt), .busy(busy), .in_pre(in_pre), .shift_en(shift_en),
      .use_cap(use_cap), .drive_en(drive_en), .done(done)
   );

   mdio_frame_reg u_reg (
      .clk(clk), .rst_n(rst_n), .load(frame_load), .load_val(host_wdata),
      .shift_en(shift_en), .use_cap(use_cap), .rise_evt(rise_evt),
      .mdio_i(mdio_i), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            irq_flag <= 1'b0;
      else if (done)                         irq_flag <= 1'b1;
      else if (stat_wr && host_wdata[STAT_IRQ]) irq_flag <= 1'b0;
   end

   assign irq     = irq_flag;
   assign mdio_o  = (busy && !in_pre) ? word[FRAME_W-1] : 1'b1;
   assign mdio_oe = drive_en;

   always_comb begin
      if (!host_addr) begin
         host_rdata = word;
      end else begin
         host_rdata            = '0;
         host_rdata[STAT_IRQ]  = irq_flag;
         host_rdata[STAT_BUSY] = busy;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mdio_o && !mdio_oe && !mdc)); // R1
   AST_PRE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      in_pre |-> (mdio_o && mdio_oe)); // R3
   AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      use_cap |-> !mdio_oe); // R6
   AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_flag); // R9
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !(stat_wr && host_wdata[STAT_IRQ])) |=> irq_flag); // R9
endmodule

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
   localparam int D   = 3;
   localparam int PRE = 32;
   localparam int FRAME_CYC = 2 * D * (PRE + 32);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_addr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq, mdc, mdio_o, mdio_oe;
   logic        mdio_i;

   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   int   rcount = 0;
   bit   done_flag = 0;
   logic b_o  [0:127];
   logic b_oe [0:127];
   logic [15:0] rd_val = 16'h0000;

   mdio_frame_master #(.CLK_DIV(D), .PRE_LEN(PRE)) u_mdio_frame_master (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // line recorder: one entry per rising MDC edge
   initial begin
      forever begin
         @(posedge mdc);
         if (rcount < 128) begin
            b_o[rcount]  = mdio_o;
            b_oe[rcount] = mdio_oe;
         end
         rcount = rcount + 1;
      end
   end

   // PHY model: presents the next bit after each falling MDC edge
   initial begin
      mdio_i = 1'b1;
      forever begin
         @(negedge mdc);
         if (rcount >= PRE + 16 && rcount < PRE + 32)
            mdio_i = rd_val[15 - (rcount - PRE - 16)];
         else
            mdio_i = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] pa, input logic [4:0] ra,
                                      input logic [1:0] ta, input logic [15:0] dat);
      return {st, op, pa, ra, ta, dat};
   endfunction

   task automatic host_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   // start a frame, optionally rewrite the word after mid_dly cycles, wait for the end
   task automatic run_frame(input logic [31:0] w, input bit mid, input int mid_dly,
                            input logic [31:0] w2, output int dur,
                            output logic [31:0] pre_v, output logic [31:0] frm_v,
                            output logic [31:0] pre_oe, output logic [31:0] frm_oe);
      int t0;
      logic [31:0] st;
      rcount = 0;
      host_write(1'b0, w);
      t0 = cyc;
      if (mid) begin
         repeat (mid_dly) @(negedge clk);
         host_write(1'b0, w2);
      end
      host_read(1'b1, st);
      while (st[1]) begin
         @(negedge clk);
         host_read(1'b1, st);
         if (cyc - t0 > FRAME_CYC + 200) begin
            chk(1'b0, "R2 frame never ended", 64'(cyc - t0), 64'(FRAME_CYC));
            break;
         end
      end
      dur = cyc - t0;
      for (int k = 0; k < 32; k++) begin
         pre_v[31-k]  = b_o[k];
         pre_oe[31-k] = b_oe[k];
         frm_v[31-k]  = b_o[PRE + k];
         frm_oe[31-k] = b_oe[PRE + k];
      end
      chk(rcount == PRE + 32, "R2 MDC period count", 64'(rcount), 64'(PRE + 32));
   endtask

   task automatic clear_irq();
      host_write(1'b1, 32'h1);
   endtask

   task automatic t_reset();
      logic [31:0] st;
      host_read(1'b1, st);
      chk(mdc == 1'b0, "R1 mdc low", 64'(mdc), 64'd0);
      chk(mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 mdio idle", {62'd0, mdio_oe, mdio_o}, 64'd1);
      chk(irq == 1'b0, "R1 irq low", 64'(irq), 64'd0);
      chk(st == 32'd0, "R1 status zero", 64'(st), 64'd0);
   endtask

   task automatic t_write_frame();
      logic [31:0] w, pv, fv, po, fo, rb;
      int dur;
      w = mk(2'b01, 2'b01, 5'h0A, 5'h13, 2'b10, 16'hBEEF);
      run_frame(w, 1'b0, 0, 32'd0, dur, pv, fv, po, fo);
      chk(dur == FRAME_CYC, "R2 busy length", 64'(dur), 64'(FRAME_CYC));
      chk(pv == 32'hFFFF_FFFF && po == 32'hFFFF_FFFF, "R3 preamble", {pv, po}, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
      chk(fv == w, "R4 write bits", 64'(fv), 64'(w));
      chk(fo == 32'hFFFF_FFFF, "R5 write drive", 64'(fo), 64'hFFFF_FFFF);
      host_read(1'b0, rb);
      chk(rb == w, "R8 word restored", 64'(rb), 64'(w));
      chk(irq == 1'b1, "R9 irq after write frame", 64'(irq), 64'd1);
      clear_irq();
   endtask

   task automatic t_read_frame(input logic [1:0] st, input logic [1:0] op,
                               input logic [1:0] ta, input logic [15:0] phy);
      logic [31:0] w, pv, fv, po, fo, rb, exp_rb;
      int dur;
      w = mk(st, op, 5'h11, 5'h05, ta, 16'h1234);
      rd_val = phy;
      run_frame(w, 1'b0, 0, 32'd0, dur, pv, fv, po, fo);
      chk(fv[31:18] == w[31:18], "R4 read header bits", 64'(fv[31:18]), 64'(w[31:18]));
      chk(fo == 32'hFFFC_0000, "R6 read release", 64'(fo), 64'hFFFC_0000);
      host_read(1'b0, rb);
      exp_rb = {w[31:16], phy};
      chk(rb == exp_rb, "R7 read data captured", 64'(rb), 64'(exp_rb));
      chk(irq == 1'b1, "R9 irq after read frame", 64'(irq), 64'd1);
      clear_irq();
   endtask

   task automatic t_noncompliant_write();
      logic [31:0] w, pv, fv, po, fo, rb;
      int dur;
      w = mk(2'b11, 2'b00, 5'h1F, 5'h00, 2'b01, 16'h0F0F);
      run_frame(w, 1'b0, 0, 32'd0, dur, pv, fv, po, fo);
      chk(fv == w, "R4 invalid fields verbatim", 64'(fv), 64'(w));
      chk(fo == 32'hFFFF_FFFF, "R5 op 00 is write-type", 64'(fo), 64'hFFFF_FFFF);
      host_read(1'b0, rb);
      chk(rb == w, "R8 restore op 00", 64'(rb), 64'(w));
      clear_irq();
   endtask

   task automatic t_irq_w1c();
      logic [31:0] w, pv, fv, po, fo, st;
      int dur;
      w = mk(2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'hA55A);
      run_frame(w, 1'b0, 0, 32'd0, dur, pv, fv, po, fo);
      host_write(1'b1, 32'h0);
      host_read(1'b1, st);
      chk(irq == 1'b1 && st[0] == 1'b1, "R9 write 0 keeps flag", {irq, st}, {1'b1, 32'h1});
      host_write(1'b1, 32'h1);
      host_read(1'b1, st);
      chk(irq == 1'b0 && st[0] == 1'b0, "R9 write 1 clears flag", {irq, st}, 64'd0);
   endtask

   task automatic t_busy();
      logic [31:0] st;
      rcount = 0;
      host_write(1'b0, mk(2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h0001));
      repeat (5) @(negedge clk);
      host_read(1'b1, st);
      chk(st[1] == 1'b1, "R10 busy during frame", 64'(st), 64'h2);
      repeat (FRAME_CYC) @(negedge clk);
      host_read(1'b1, st);
      chk(st[1] == 1'b0, "R10 busy clear after frame", 64'(st), 64'h1);
      clear_irq();
   endtask

   task automatic t_midframe();
      logic [31:0] a, b, pv, fv, po, fo, rb;
      int dur;
      a = mk(2'b01, 2'b01, 5'h06, 5'h07, 2'b10, 16'h1111);
      b = mk(2'b01, 2'b10, 5'h19, 5'h0C, 2'b10, 16'h9C3E);
      rd_val = 16'h0000;
      run_frame(a, 1'b1, 20, b, dur, pv, fv, po, fo);
      chk(dur == FRAME_CYC, "R11 no restart", 64'(dur), 64'(FRAME_CYC));
      chk(fv == b, "R11 new word sent", 64'(fv), 64'(b));
      chk(fo == 32'hFFFF_FFFF, "R11 type kept from start", 64'(fo), 64'hFFFF_FFFF);
      host_read(1'b0, rb);
      chk(rb == b, "R11 new word restored", 64'(rb), 64'(b));
      clear_irq();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_frame();
      t_read_frame(2'b01, 2'b10, 2'b10, 16'hC3A5);
      t_read_frame(2'b00, 2'b11, 2'b00, 16'h8001);
      t_noncompliant_write();
      t_irq_w1c();
      t_busy();
      t_midframe();
      t_reset();
      finish_run();
   end

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule